// File: doc/BRIEF.md
# Deadline Timer Stall Unit

This block gives a small in-order core a way to pace software to the clock cycle. It holds a bank of countdown timers. Each one falls by one per cycle until it reaches zero, and then it rests there. When the core meets a deadline instruction, it presents a request that names one timer and carries a timeout. The unit holds the core stalled for as long as the named timer is nonzero. In the cycle the timer is zero, the unit drops the stall, the instruction retires and the timer is rearmed from the timeout.

Because the rearm happens at the moment of retirement, the next deadline on the same timer retires exactly a timeout's worth of cycles later. This holds as long as the code in between ran for fewer cycles than that. Loops and straight runs of code therefore get fixed periods that do not drift. Four timers let nested pacing loops, such as a line period and a per-character period, run side by side.

Reset is asynchronous and active low. Its release is synchronised to the clock inside the block.

Top module: `deadline_stall_unit`

## Requirements
- R1: After reset every timer reads zero, so the first request to any timer causes no stall.
- R2: While a request is presented and the named timer is nonzero, `stall_o` is high in that same cycle.
- R3: When a request is presented and the named timer is zero, `stall_o` is low in that cycle and the request retires. The timer is rearmed so that one cycle later it reads timeout minus one, or zero when the timeout is 0.
- R4: Every timer that is nonzero and is not being rearmed falls by exactly one per clock cycle.
- R5: A timer that has reached zero stays at zero and never wraps. A request made long after the timer expired retires at once.
- R6: At most one timer is rearmed per cycle. A request affects only the timer it names (`req_sel_i` value k selects timer k).
- R7: With `req_valid_i` low, `stall_o` is low and no timer is rearmed.
- R8: Two consecutive deadlines on one timer with timeout N ≥ 1 retire exactly N cycles apart, provided the second request is made fewer than N cycles after the first retires. A deadline repeated in a loop makes each pass last at least N cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid_i | input | 1 | A deadline request is presented this cycle |
| req_sel_i | input | 2 | Index of the timer named by the request |
| req_timeout_i | input | 16 | Value used to rearm the named timer on retirement |
| stall_o | output | 1 | Core must hold the deadline instruction this cycle |

## Verification
The bench aims at the retire-to-retire spacing. An off-by-one in the rearm value, such as loading N instead of N-1, would stretch every loop period by one cycle, and the spacing checks catch that. It also tries a request made long after expiry. A timer that wraps below zero would then stall for about 65535 cycles instead of zero. Timeout 0 and timeout 1 are exercised, since a mishandled rearm there could leave the timer at all ones. Interleaved requests to different timers show whether a rearm or a decrement leaks into a timer that was not named.

// File: rtl/dl_pkg.sv
package dl_pkg;
  localparam int unsigned DL_NUM_TIMERS = 4;
  localparam int unsigned DL_TIMER_W    = 16;
  localparam int unsigned DL_SEL_W      = $clog2(DL_NUM_TIMERS);

  typedef logic [DL_TIMER_W-1:0] dl_count_t;
  typedef logic [DL_SEL_W-1:0]   dl_sel_t;
endpackage

// File: rtl/dl_rst_sync.sv
module dl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/dl_timer.sv
module dl_timer #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] timeout_i,
  output logic [W-1:0] count_o,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;
  logic [W-1:0] reload_val;

  // The retiring cycle already counts as the first elapsed cycle.
  always_comb begin
    reload_val = (timeout_i == '0) ? '0 : timeout_i - 1'b1;
    cnt_en     = load_i || (cnt_q != '0);
    if (load_i) cnt_d = reload_val;
    else        cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
  assign zero_o  = (cnt_q == '0);

  assert_hold_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_o && !load_i) |=> zero_o);

  assert_count_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!zero_o && !load_i) |=> (count_o == $past(count_o) - 1'b1));

  assert_rearm_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (($past(timeout_i) == '0) ? zero_o : (count_o == $past(timeout_i) - 1'b1)));
endmodule

// File: rtl/dl_select.sv
module dl_select #(
  parameter int unsigned N     = 4,
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid_i,
  input  logic [SEL_W-1:0] req_sel_i,
  input  logic [N-1:0]     zero_i,
  output logic [N-1:0]     load_o,
  output logic             stall_o
);
  logic [N-1:0] sel_dec;

  always_comb begin
    sel_dec = '0;
    if (req_valid_i) sel_dec[req_sel_i] = 1'b1;
  end

  assign load_o  = sel_dec & zero_i;
  assign stall_o = |(sel_dec & ~zero_i);

  assert_single_rearm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_o));

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid_i |-> (!stall_o && load_o == '0));

  assert_retire_or_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_i |-> (stall_o ^ (load_o != '0)));
endmodule

// File: rtl/deadline_stall_unit.sv
module deadline_stall_unit
  import dl_pkg::*;
#(
  parameter int unsigned NUM_TIMERS = DL_NUM_TIMERS,
  parameter int unsigned TIMER_W    = DL_TIMER_W,
  localparam int unsigned SEL_W     = $clog2(NUM_TIMERS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid_i,
  input  logic [SEL_W-1:0]   req_sel_i,
  input  logic [TIMER_W-1:0] req_timeout_i,
  output logic               stall_o
);
  logic                        rst_sync_n;
  logic [NUM_TIMERS-1:0]       load_vec;
  logic [NUM_TIMERS-1:0]       zero_vec;
  logic [TIMER_W-1:0]          count_arr [NUM_TIMERS];

  dl_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dl_select #(.N(NUM_TIMERS), .SEL_W(SEL_W)) u_sel (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .req_valid_i (req_valid_i),
    .req_sel_i   (req_sel_i),
    .zero_i      (zero_vec),
    .load_o      (load_vec),
    .stall_o     (stall_o)
  );

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_tmr
    dl_timer #(.W(TIMER_W)) u_tmr (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .load_i    (load_vec[i]),
      .timeout_i (req_timeout_i),
      .count_o   (count_arr[i]),
      .zero_o    (zero_vec[i])
    );

    // R6: a timer not named by the request keeps its own course.
    assert_untouched_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (!(req_valid_i && req_sel_i == SEL_W'(i)) && count_arr[i] != '0)
        |=> (count_arr[i] == $past(count_arr[i]) - 1'b1));
  end

  assert_reset_zero_R1: assert property (@(posedge clk)
    !rst_sync_n |-> (zero_vec == '1));
endmodule

// File: tb/tb_deadline_stall_unit.sv
module tb_deadline_stall_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_sel;
  logic [15:0] req_timeout;
  logic        stall;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int model [NT];
  bit done = 0;

  deadline_stall_unit dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid_i   (req_valid),
    .req_sel_i     (req_sel),
    .req_timeout_i (req_timeout),
    .stall_o       (stall)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // One clock: drive at negedge, compare, then advance the model at posedge.
  task automatic step(bit v, int s, int to, string req, output bit stalled);
    int exp;
    @(negedge clk);
    req_valid   = v;
    req_sel     = 2'(s);
    req_timeout = 16'(to);
    #1;
    exp = (v && model[s] != 0) ? 1 : 0;
    check(req, int'(stall), exp);
    stalled = stall;
    @(posedge clk);
    cyc++;
    for (int i = 0; i < NT; i++) begin
      if (v && s == i && model[i] == 0) model[i] = (to > 0) ? to - 1 : 0;
      else if (model[i] > 0) model[i]--;
    end
  endtask

  task automatic idle(int n, string req);
    bit st;
    for (int k = 0; k < n; k++) step(0, 0, 0, req, st);
  endtask

  // Present a deadline until it retires; returns the cycle of retirement.
  task automatic deadline(int s, int to, string req, output int retire_cyc);
    bit st;
    int guard = 0;
    do begin
      retire_cyc = cyc;
      step(1, s, to, req, st);
      guard++;
    end while (st && guard < 70000);
  endtask

  initial begin
    int r0, r1, r2;
    bit st;
    for (int i = 0; i < NT; i++) model[i] = 0;
    rst_n = 1'b0; req_valid = 0; req_sel = 0; req_timeout = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset stall", int'(stall), 0);
    rst_n = 1'b1;
    idle(4, "R7 idle after reset");

    // R1: first request on every timer retires at once
    for (int i = 0; i < NT; i++) begin
      step(1, i, 0, "R1 first request", st);
      check("R1 no stall", int'(st), 0);
    end

    // R3/R8: spacing between two deadlines on timer 0 with gap work
    deadline(0, 8, "R3 arm t0", r0);
    idle(2, "R4 work");
    deadline(0, 10, "R2 stall t0", r1);
    check("R8 spacing 8", r1 - r0, 8);

    // R8: loop with period 5 on timer 1, with 1 cycle of work in between
    deadline(1, 5, "R8 loop arm", r0);
    for (int k = 0; k < 4; k++) begin
      idle(1, "R8 loop body");
      deadline(1, 5, "R8 loop", r1);
      check("R8 loop period", r1 - r0, 5);
      r0 = r1;
    end

    // R6: interleave timers 2 and 3
    deadline(2, 20, "R6 arm t2", r0);
    deadline(3, 6, "R6 arm t3", r2);
    check("R6 t3 not blocked by t2", r2 - r0, 1);
    deadline(3, 6, "R6 t3 again", r1);
    check("R6 t3 spacing", r1 - r2, 6);
    deadline(2, 3, "R6 t2 again", r1);
    check("R6 t2 spacing", r1 - r0, 20);

    // R5: let timer 0 expire well past zero, then request
    deadline(0, 4, "R5 arm", r0);
    idle(40, "R5 idle");
    step(1, 0, 7, "R5 no wrap", st);
    check("R5 expired retires at once", int'(st), 0);

    // R3: timeout 0 and timeout 1 leave the timer at zero next cycle
    idle(10, "R3 settle");
    step(1, 1, 0, "R3 timeout0", st);
    step(1, 1, 1, "R3 after timeout0", st);
    check("R3 timeout0 no stall", int'(st), 0);
    step(1, 1, 9, "R3 after timeout1", st);
    check("R3 timeout1 no stall", int'(st), 0);

    // R7: valid low never rearms, so timer 1 keeps counting down
    idle(3, "R7 valid low");
    deadline(1, 2, "R7 rearm after idle", r1);

    // R8: work longer than the period gives no stall
    deadline(2, 3, "R8 arm", r0);
    idle(10, "R8 long work");
    step(1, 2, 3, "R8 late", st);
    check("R8 late no stall", int'(st), 0);

    idle(3, "R7 tail");
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule